// File: doc/BRIEF.md
# Symmetric Decimating Channel FIR with Shared Coefficient Banks

This block is the channel-filter stage of a two-channel digital receiver. Each channel takes complex samples of 21 bits per rail through a valid/ready handshake. It filters the I and Q rails with a linear-phase FIR whose impulse response is mirror-symmetric, and it produces one output for every D accepted inputs. A channel runs either as a 21-tap filter that always decimates by 2 or as a 63-tap filter that decimates by 2 or by 4. Only the outputs that are kept are computed. Mirrored delay-line samples are summed before the multiply, so each output costs one multiply per unique coefficient per rail.

The two channels share two coefficient banks of 32 signed 16-bit entries each. A host loads the banks through a write port. Each channel picks its bank with a select input, so the channels can use different banks or share one. At the start of each output computation, a channel copies its selected bank into a private snapshot. A host write therefore never disturbs a result that is already being formed.

Top module: `sym_dec_fir`

## Requirements
- R1: `in_ready[c]` is high after reset and while channel c collects samples. A sample is taken on a cycle with `in_valid[c]` and `in_ready[c]` both high. After the D-th sample of a group is taken, `in_ready[c]` stays low for exactly NU cycles, where NU = 11 in 21-tap mode and 32 in 63-tap mode.
- R2: Channel c produces exactly one output per D accepted samples. With `cfg_long[c]`=0, D is 2 and `cfg_dec4[c]` has no effect. With `cfg_long[c]`=1, D is 4 when `cfg_dec4[c]`=1 and 2 when it is 0.
- R3: Each output is y = sum over j of h[j]·x[n−j], for j from 0 to N−1, where x[n] is the newest accepted sample. With N taps, h[j] = coef[j] for j ≤ (N−1)/2 and h[j] = coef[N−1−j] otherwise. The 21-tap mode uses bank addresses 0..10, with address 10 as the unpaired centre. The 63-tap mode uses addresses 0..31, with address 31 as the centre. The sum is rounded as floor((sum + 2^14) / 2^15).
- R4: `out_valid[c]` is a one-cycle pulse. It rises NU clock edges after the edge that took the D-th sample. `out_i`/`out_q` change only when a pulse is issued and otherwise hold their value.
- R5: Reset clears both delay lines, both banks, all outputs and all group counters to zero.
- R6: A write with `cw_en`=1 stores `cw_data` at address `cw_addr` (0..31) of bank `cw_bank` (0 or 1). `cfg_bank[c]` selects the bank that channel c uses, and both channels may select the same bank.
- R7: A channel copies its selected bank on the edge that takes the D-th sample. A bank write made while an output is being computed affects only later outputs.
- R8: A rounded result above 2^20−1 is output as 2^20−1, and one below −2^20 is output as −2^20.
- R9: The I and Q rails are filtered independently with the same coefficients and delay-line timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_long | input | NCH | Per channel: 1 selects 63 taps, 0 selects 21 taps |
| cfg_dec4 | input | NCH | Per channel: decimate by 4 in 63-tap mode |
| cfg_bank | input | NCH | Per channel: coefficient bank select |
| in_valid | input | NCH | Per channel: input sample valid |
| in_ready | output | NCH | Per channel: ready to take a sample |
| in_i | input | NCH*DW | In-phase samples, channel c at bits [c*DW +: DW] |
| in_q | input | NCH*DW | Quadrature samples, same packing |
| out_valid | output | NCH | Per channel: output strobe |
| out_i | output | NCH*DW | Filtered in-phase results |
| out_q | output | NCH*DW | Filtered quadrature results |
| cw_en | input | 1 | Coefficient write enable |
| cw_bank | input | 1 | Bank written |
| cw_addr | input | 5 | Coefficient address |
| cw_data | input | CW | Signed coefficient value |

## Verification
A group's result is due NU clock edges after the edge that takes its D-th sample: 11 edges in 21-tap mode and 32 in 63-tap mode. The ready line drops on that same edge and returns together with the strobe. The bench drives each sample just after a falling edge and counts the rising edges until the strobe is seen at a falling edge. It compares that count with NU, and only then compares the output data with the value it has computed from its own delay-line and bank model. After every non-final sample of a group, the bench confirms at the next falling edge that no strobe has appeared. For the mid-computation write, the expected value uses the bank as it stood when the group closed.

// File: rtl/sym_dec_fir.sv
module sym_dec_fir #(
  parameter int NCH    = 2,
  parameter int DW     = 21,
  parameter int CW     = 16,
  parameter int ACCW   = 44,
  parameter int FRAC   = 15,
  parameter int TAPS_S = 21,
  parameter int TAPS_L = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cfg_long,
  input  logic [NCH-1:0]    cfg_dec4,
  input  logic [NCH-1:0]    cfg_bank,
  input  logic [NCH-1:0]    in_valid,
  output logic [NCH-1:0]    in_ready,
  input  logic [NCH*DW-1:0] in_i,
  input  logic [NCH*DW-1:0] in_q,
  output logic [NCH-1:0]    out_valid,
  output logic [NCH*DW-1:0] out_i,
  output logic [NCH*DW-1:0] out_q,
  input  logic              cw_en,
  input  logic              cw_bank,
  input  logic [4:0]        cw_addr,
  input  logic [CW-1:0]     cw_data
);
  localparam int NCOEF = 32;
  localparam int CA    = $clog2(NCOEF);
  localparam int IW    = $clog2(TAPS_L + 1);
  localparam int PW    = DW + 1 + CW;
  localparam logic signed [ACCW-1:0] RND  = ACCW'(1) <<< (FRAC - 1);
  localparam logic signed [ACCW-1:0] SMAX = (ACCW'(1) <<< (DW - 1)) - ACCW'(1);
  localparam logic signed [ACCW-1:0] SMIN = -(ACCW'(1) <<< (DW - 1));

  logic signed [CW-1:0] bank [2][NCOEF];

  function automatic logic signed [DW-1:0] sat_rnd(input logic signed [ACCW-1:0] v);
    logic signed [ACCW-1:0] s;
    s = (v + RND) >>> FRAC;
    if (s > SMAX)      return DW'(SMAX);
    else if (s < SMIN) return DW'(SMIN);
    else               return DW'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < NCOEF; a++) bank[b][a] <= '0;
    end else if (cw_en) begin
      bank[cw_bank][cw_addr[CA-1:0]] <= cw_data;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DW-1:0]   dli [TAPS_L];
    logic signed [DW-1:0]   dlq [TAPS_L];
    logic signed [CW-1:0]   shad [NCOEF];
    logic                   busy, ov;
    logic [2:0]             cnt;
    logic [CA-1:0]          k;
    logic signed [ACCW-1:0] acci, accq;
    logic signed [DW-1:0]   oi, oq;

    logic [2:0]             dec;
    logic [IW-1:0]          ntap, ctr, kx, mir;
    logic                   take, last;
    logic signed [DW:0]     prei, preq;
    logic signed [PW-1:0]   prodi, prodq;
    logic signed [ACCW-1:0] sumi, sumq;

    always_comb begin
      dec   = (cfg_long[c] && cfg_dec4[c]) ? 3'd4 : 3'd2;
      ntap  = cfg_long[c] ? IW'(TAPS_L) : IW'(TAPS_S);
      ctr   = (ntap - IW'(1)) >> 1;
      kx    = IW'(k);
      mir   = ntap - IW'(1) - kx;
      take  = in_valid[c] && !busy;
      last  = (kx == ctr);
      prei  = last ? (DW+1)'(dli[kx]) : (DW+1)'(dli[kx]) + (DW+1)'(dli[mir]);
      preq  = last ? (DW+1)'(dlq[kx]) : (DW+1)'(dlq[kx]) + (DW+1)'(dlq[mir]);
      prodi = PW'(prei) * PW'(shad[k]);
      prodq = PW'(preq) * PW'(shad[k]);
      sumi  = acci + ACCW'(prodi);
      sumq  = accq + ACCW'(prodq);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < TAPS_L; i++) begin
          dli[i] <= '0;
          dlq[i] <= '0;
        end
        for (int a = 0; a < NCOEF; a++) shad[a] <= '0;
        busy <= 1'b0;
        ov   <= 1'b0;
        cnt  <= '0;
        k    <= '0;
        acci <= '0;
        accq <= '0;
        oi   <= '0;
        oq   <= '0;
      end else begin
        ov <= 1'b0;
        if (take) begin
          dli[0] <= in_i[c*DW +: DW];
          dlq[0] <= in_q[c*DW +: DW];
          for (int i = 1; i < TAPS_L; i++) begin
            dli[i] <= dli[i-1];
            dlq[i] <= dlq[i-1];
          end
          if (cnt == dec - 3'd1) begin
            cnt  <= '0;
            busy <= 1'b1;
            k    <= '0;
            acci <= '0;
            accq <= '0;
            for (int a = 0; a < NCOEF; a++) shad[a] <= bank[cfg_bank[c]][a];
          end else begin
            cnt <= cnt + 3'd1;
          end
        end
        if (busy) begin
          if (last) begin
            busy <= 1'b0;
            ov   <= 1'b1;
            oi   <= sat_rnd(sumi);
            oq   <= sat_rnd(sumq);
          end else begin
            k    <= k + CA'(1);
            acci <= sumi;
            accq <= sumq;
          end
        end
      end
    end

    assign in_ready[c]         = !busy;
    assign out_valid[c]        = ov;
    assign out_i[c*DW +: DW]   = oi;
    assign out_q[c*DW +: DW]   = oq;
  end
endmodule

// File: rtl/sym_dec_fir_chk.sv
module sym_dec_fir_chk #(
  parameter int NCH = 2,
  parameter int DW  = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    cfg_long,
  input logic [NCH-1:0]    cfg_dec4,
  input logic [NCH-1:0]    in_valid,
  input logic [NCH-1:0]    in_ready,
  input logic [NCH-1:0]    out_valid,
  input logic [NCH*DW-1:0] out_i,
  input logic [NCH*DW-1:0] out_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic [7:0] low_run;
    logic [3:0] n_acc;
    logic [3:0] want_d;
    logic [7:0] want_nu;
    logic       acc;

    assign acc     = in_valid[c] && in_ready[c];
    assign want_d  = (cfg_long[c] && cfg_dec4[c]) ? 4'd4 : 4'd2;
    assign want_nu = cfg_long[c] ? 8'd32 : 8'd11;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        low_run <= '0;
        n_acc   <= '0;
      end else begin
        low_run <= in_ready[c] ? 8'd0 : low_run + 8'd1;
        if (out_valid[c]) n_acc <= acc ? 4'd1 : 4'd0;
        else if (acc)     n_acc <= n_acc + 4'd1;
      end
    end

    assert_ready_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[c] |-> (low_run == want_nu));

    assert_group_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[c] |-> (n_acc == want_d));

    assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[c] |=> !out_valid[c]);

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[c] |-> ($stable(out_i[c*DW +: DW]) && $stable(out_q[c*DW +: DW])));
  end
endmodule

bind sym_dec_fir sym_dec_fir_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_long(cfg_long), .cfg_dec4(cfg_dec4),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_i(out_i), .out_q(out_q)
);

// File: tb/sym_dec_fir_test.sv
`timescale 1ns/1ps
module sym_dec_fir_test;
  localparam int NCH = 2;
  localparam int DW  = 21;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    cfg_long = '0, cfg_dec4 = '0, cfg_bank = '0, in_valid = '0;
  logic [NCH-1:0]    in_ready, out_valid;
  logic [NCH*DW-1:0] in_i = '0, in_q = '0, out_i, out_q;
  logic              cw_en = 1'b0, cw_bank = 1'b0;
  logic [4:0]        cw_addr = '0;
  logic [15:0]       cw_data = '0;

  sym_dec_fir uut (
    .clk(clk), .rst_n(rst_n), .cfg_long(cfg_long), .cfg_dec4(cfg_dec4),
    .cfg_bank(cfg_bank), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i),
    .out_q(out_q), .cw_en(cw_en), .cw_bank(cw_bank), .cw_addr(cw_addr),
    .cw_data(cw_data)
  );

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0;
  int seed = 12345;
  int bk [2][32];
  int hi [2][63];
  int hq [2][63];
  int grp [2];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input int bits);
    int v;
    seed = seed * 1103515245 + 12345;
    v = (seed >>> 8) & ((1 << bits) - 1);
    if (v >= (1 << (bits - 1))) v -= (1 << bits);
    return v;
  endfunction

  function automatic longint model(input int ch, input bit q, input int cf[32]);
    longint acc = 0;
    int n = cfg_long[ch] ? 63 : 21;
    for (int j = 0; j < n; j++) begin
      int a = (j <= (n - 1) / 2) ? j : n - 1 - j;
      acc += longint'(cf[a]) * longint'(q ? hq[ch][j] : hi[ch][j]);
    end
    acc = (acc + 16384) >>> 15;
    if (acc > 1048575)  acc = 1048575;
    if (acc < -1048576) acc = -1048576;
    return acc;
  endfunction

  task automatic cwrite(input int b, input int a, input int v);
    @(negedge clk);
    cw_en = 1'b1; cw_bank = b[0]; cw_addr = a[4:0]; cw_data = v[15:0];
    @(negedge clk);
    cw_en = 1'b0;
    bk[b][a] = v;
  endtask

  task automatic feed(input int ch, input int vi, input int vq, input bit mid,
                      input int mb, input int ma, input int mv);
    int d, nu, lat;
    int snap [32];
    d  = (cfg_long[ch] && cfg_dec4[ch]) ? 4 : 2;
    nu = cfg_long[ch] ? 32 : 11;
    @(negedge clk);
    check(in_ready[ch] == 1'b1, "R1", "ready while collecting", in_ready[ch], 1);
    in_valid[ch] = 1'b1;
    in_i[ch*DW +: DW] = vi[DW-1:0];
    in_q[ch*DW +: DW] = vq[DW-1:0];
    @(posedge clk);
    for (int j = 62; j > 0; j--) begin
      hi[ch][j] = hi[ch][j-1];
      hq[ch][j] = hq[ch][j-1];
    end
    hi[ch][0] = vi;
    hq[ch][0] = vq;
    @(negedge clk);
    in_valid[ch] = 1'b0;
    grp[ch]++;
    if (grp[ch] == d) begin
      grp[ch] = 0;
      snap = bk[cfg_bank[ch]];
      check(in_ready[ch] == 1'b0, "R1", "ready low after group", in_ready[ch], 0);
      lat = 0;
      while (!out_valid[ch] && lat < 100) begin
        if (mid && lat == 0) begin
          cw_en = 1'b1; cw_bank = mb[0]; cw_addr = ma[4:0]; cw_data = mv[15:0];
        end
        @(posedge clk);
        @(negedge clk);
        cw_en = 1'b0;
        lat++;
      end
      if (mid) bk[mb][ma] = mv;
      check(lat == nu, "R4", "strobe latency", lat, nu);
      check($signed(out_i[ch*DW +: DW]) == model(ch, 1'b0, snap), "R3", "I result",
            $signed(out_i[ch*DW +: DW]), model(ch, 1'b0, snap));
      check($signed(out_q[ch*DW +: DW]) == model(ch, 1'b1, snap), "R9", "Q result",
            $signed(out_q[ch*DW +: DW]), model(ch, 1'b1, snap));
      check(in_ready[ch] == 1'b1, "R1", "ready back with strobe", in_ready[ch], 1);
    end else begin
      check(out_valid[ch] == 1'b0, "R2", "no strobe mid-group", out_valid[ch], 0);
    end
  endtask

  task automatic feed_rand(input int ch, input int n);
    for (int s = 0; s < n; s++) feed(ch, rnd(21), rnd(21), 1'b0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int a = 0; a < 32; a++) bk[b][a] = 0;
    for (int c = 0; c < 2; c++) begin
      grp[c] = 0;
      for (int j = 0; j < 63; j++) begin hi[c][j] = 0; hq[c][j] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: reset state at the ports
    check(in_ready == 2'b11, "R5", "ready after reset", in_ready, 3);
    check(out_valid == 2'b00, "R5", "no strobe after reset", out_valid, 0);
    check(out_i == '0 && out_q == '0, "R5", "outputs zero", out_i, 0);
    // R5: banks cleared, so the first group yields zero
    feed(0, 500000, -400000, 1'b0, 0, 0, 0);
    feed(0, 300000, 200000, 1'b0, 0, 0, 0);
    check(out_i[0 +: DW] == '0, "R5", "zero banks give zero", $signed(out_i[0 +: DW]), 0);

    // R6: load both banks
    for (int a = 0; a < 32; a++) cwrite(0, a, rnd(16));
    for (int a = 0; a < 32; a++) cwrite(1, a, rnd(16));

    // R2/R3: short mode, dec4 set but ignored, impulse sweep then random
    @(negedge clk); cfg_long[0] = 1'b0; cfg_dec4[0] = 1'b1; cfg_bank[0] = 1'b0;
    feed(0, 0, 0, 1'b0, 0, 0, 0);
    feed(0, 32768, -32768, 1'b0, 0, 0, 0);
    for (int s = 0; s < 22; s++) feed(0, 0, 0, 1'b0, 0, 0, 0);
    feed_rand(0, 40);

    // R6: channel 1 shares bank 0, long mode decimate by 2
    @(negedge clk); cfg_long[1] = 1'b1; cfg_dec4[1] = 1'b0; cfg_bank[1] = 1'b0;
    feed(1, 65536, 16384, 1'b0, 0, 0, 0);
    for (int s = 0; s < 63; s++) feed(1, 0, 0, 1'b0, 0, 0, 0);
    feed_rand(1, 70);

    // R2: long mode decimate by 4 on bank 1
    @(negedge clk); cfg_long[0] = 1'b1; cfg_dec4[0] = 1'b1; cfg_bank[0] = 1'b1;
    feed_rand(0, 80);

    // R6: short mode on bank 1
    @(negedge clk); cfg_long[1] = 1'b0; cfg_bank[1] = 1'b1;
    feed_rand(1, 20);

    // R7: write to the bank in use while the group computes
    feed_rand(0, 3);
    feed(0, rnd(21), rnd(21), 1'b1, 1, 31, -20000);
    feed_rand(0, 4);

    // R8: saturation at both limits
    for (int a = 0; a < 32; a++) cwrite(1, a, 32767);
    @(negedge clk); cfg_dec4[0] = 1'b0;
    for (int s = 0; s < 64; s++) feed(0, 1048575, -1048576, 1'b0, 0, 0, 0);
    check($signed(out_i[0 +: DW]) == 1048575, "R8", "positive clamp",
          $signed(out_i[0 +: DW]), 1048575);
    check($signed(out_q[0 +: DW]) == -1048576, "R8", "negative clamp",
          $signed(out_q[0 +: DW]), -1048576);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule